// File: doc/BRIEF.md
# ADC Conversion Command Queue Sequencer

This block runs the analog-to-digital conversions of a chip from a 64-entry table of command words that software fills in. The table holds two queues. The first always begins at entry 0. The second begins at an index held on a boundary input, and that index also closes the first queue. Each command word picks an input channel, a reference selection and a sampling duration. It can also tell the sequencer to stop after its own conversion until the queue is triggered again. The converter is a plain handshake. The sequencer raises a sample phase for the programmed number of clocks and then pulses start. The converter returns a 10-bit code with a done strobe.

Each code is stored in a 64-entry result table at the index of the command that produced it. Software reads it back in one of three 16-bit alignments, chosen per access. Queue 1 has priority. If its trigger arrives while queue 2 is converting, queue 1 takes over at the next command boundary. Queue 2 then carries on from where it stopped.

Top module: `adc_cmd_sequencer`

## Requirements
- R1: A command word (bit 0 = lsb) carries the channel in bits 5:0, the sample-time code in bits 7:6, the reference select in bit 8 and the pause flag in bit 9. During a conversion of that command, `conv_chan` and `conv_ref` show those fields.
- R2: For sample-time codes 0, 1, 2 and 3, `conv_sample` is high for exactly 2, 4, 8 and 16 cycles. It is followed at once by a single-cycle `conv_start`, and the two are never high together.
- R3: A pulse on `trig_q1` while queue 1 is stopped starts queue 1 at entry 0. Queue 1 then converts the entries in ascending order.
- R4: Queue 1 stops on reaching the entry numbered `q2_base`, without converting that entry.
- R5: A pulse on `trig_q2` while queue 2 is stopped starts queue 2 at entry `q2_base`. Queue 2 then runs upward and stops after entry 63.
- R6: Channel code 63 marks end of queue. The active queue stops and no conversion is issued for that entry.
- R7: After a command with the pause flag completes, its queue issues no further conversion until its own trigger arrives. It then continues with the next entry.
- R8: On `conv_done`, `conv_data` is stored as result word n, where n is the index of the command being converted.
- R9: With `rd_fmt` = 0 (or 3), `rd_data` is the result in bits 9:0 with bits 15:10 zero.
- R10: With `rd_fmt` = 1, `rd_data` is the result in bits 15:6 with bits 5:0 zero.
- R11: With `rd_fmt` = 2, `rd_data` is {inverted result bit 9, result bits 8:0, six zeros}, so the mid-scale code 0x200 reads as 0.
- R12: A queue 1 trigger while queue 2 is running takes effect at the next command boundary. Queue 2 resumes at its next entry once queue 1 stops.
- R13: A trigger for a queue that is already running has no effect.
- R14: After reset both queues are stopped and `conv_sample` and `conv_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command table write enable |
| cmd_waddr | input | 6 | Command table write index |
| cmd_wdata | input | 16 | Command word to write |
| q2_base | input | 6 | First entry of queue 2, end of queue 1 |
| trig_q1 | input | 1 | Queue 1 trigger pulse |
| trig_q2 | input | 1 | Queue 2 trigger pulse |
| conv_sample | output | 1 | Sample phase in progress |
| conv_start | output | 1 | Single-cycle conversion start |
| conv_chan | output | 6 | Channel of the current conversion |
| conv_ref | output | 1 | Alternate reference select |
| conv_done | input | 1 | Converter finished, data valid |
| conv_data | input | 10 | Converted code |
| rd_addr | input | 6 | Result table read index |
| rd_fmt | input | 2 | Read alignment: 0 right, 1 left, 2 left signed |
| rd_data | output | 16 | Aligned result word |

## Verification
The two functions that can land in the same cycle are completion of a queue 2 conversion and arrival of a queue 1 trigger. The bench drives `trig_q1` on the very cycle it asserts `conv_done` for a queue 2 command. The next start must then carry queue 1's entry 0 channel. Every queue 1 channel must follow in order, and only after that does queue 2's next channel appear. A trigger is also pulsed against a running queue 1 at its own completion edge, and the channel sequence must show no restart.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        FMT_RIGHT  = 2'd0,
        FMT_LEFT   = 2'd1,
        FMT_SIGNED = 2'd2,
        FMT_ALT    = 2'd3
    } rd_fmt_e;

    typedef enum logic [1:0] {
        E_IDLE,
        E_HOLD,
        E_START,
        E_WAIT
    } eng_e;

    typedef enum logic [1:0] {
        Q_OFF,
        Q_RUN,
        Q_PAUSE
    } qstate_e;

endpackage

// File: rtl/cmd_table.sv
module cmd_table #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/result_table.sv
module result_table
    import adc_seq_pkg::*;
#(
    parameter int AW    = 6,
    parameter int RW    = 10,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [RW-1:0]    wdata,
    input  logic [AW-1:0]    raddr,
    input  logic [1:0]       fmt,
    output logic [OUT_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    localparam int PAD   = OUT_W - RW;

    logic [RW-1:0] mem [DEPTH];
    logic [RW-1:0] word;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign word = mem[raddr];

    always_comb begin
        case (rd_fmt_e'(fmt))
            FMT_LEFT:   rdata = {word, {PAD{1'b0}}};
            FMT_SIGNED: rdata = {~word[RW-1], word[RW-2:0], {PAD{1'b0}}};
            default:    rdata = {{PAD{1'b0}}, word};
        endcase
    end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int AW     = 6,
    parameter int DW     = 16,
    parameter int SAMP_W = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_q1,
    input  logic          trig_q2,
    input  logic [AW-1:0] q2_base,
    output logic [AW-1:0] cmd_raddr,
    input  logic [DW-1:0] cmd_rdata,
    output logic          conv_sample,
    output logic          conv_start,
    output logic [AW-1:0] conv_chan,
    output logic          conv_ref,
    input  logic          conv_done,
    output logic          res_we,
    output logic [AW-1:0] res_waddr
);
    localparam int PW          = AW + 1;
    localparam int IST_LO      = AW;
    localparam int REF_BIT     = AW + 2;
    localparam int PAUSE_BIT   = AW + 3;
    localparam logic [AW-1:0] EOQ_CODE = '1;

    typedef struct packed {
        eng_e              eng;
        logic              cur_q2;
        logic [PW-1:0]     ptr1;
        logic [PW-1:0]     ptr2;
        qstate_e           st1;
        qstate_e           st2;
        logic [SAMP_W-1:0] cnt;
        logic [AW-1:0]     chan;
        logic              ref_sel;
        logic              pause;
    } seq_state_t;

    seq_state_t q, d;

    logic          pick_q2;
    logic [PW-1:0] pick_ptr;
    logic [AW-1:0] f_chan;
    logic [1:0]    f_ist;
    logic          at_end;

    assign pick_q2   = (q.st1 != Q_RUN);
    assign pick_ptr  = pick_q2 ? q.ptr2 : q.ptr1;
    assign cmd_raddr = pick_ptr[AW-1:0];
    assign f_chan    = cmd_rdata[AW-1:0];
    assign f_ist     = cmd_rdata[IST_LO+1:IST_LO];
    assign at_end    = pick_ptr[AW] || (f_chan == EOQ_CODE) ||
                       (!pick_q2 && (pick_ptr >= {1'b0, q2_base}));

    always_comb begin
        d         = q;
        res_we    = 1'b0;
        res_waddr = q.cur_q2 ? q.ptr2[AW-1:0] : q.ptr1[AW-1:0];

        case (q.eng)
            E_IDLE: begin
                if (q.st1 == Q_RUN || q.st2 == Q_RUN) begin
                    if (at_end) begin
                        if (pick_q2) d.st2 = Q_OFF;
                        else         d.st1 = Q_OFF;
                    end else begin
                        d.eng     = E_HOLD;
                        d.cur_q2  = pick_q2;
                        d.cnt     = (SAMP_W'(2) << f_ist) - SAMP_W'(1);
                        d.chan    = f_chan;
                        d.ref_sel = cmd_rdata[REF_BIT];
                        d.pause   = cmd_rdata[PAUSE_BIT];
                    end
                end
            end
            E_HOLD: begin
                if (q.cnt == '0) d.eng = E_START;
                else             d.cnt = q.cnt - SAMP_W'(1);
            end
            E_START: d.eng = E_WAIT;
            E_WAIT: begin
                if (conv_done) begin
                    res_we = 1'b1;
                    d.eng  = E_IDLE;
                    if (q.cur_q2) begin
                        d.ptr2 = q.ptr2 + PW'(1);
                        if (q.pause) d.st2 = Q_PAUSE;
                    end else begin
                        d.ptr1 = q.ptr1 + PW'(1);
                        if (q.pause) d.st1 = Q_PAUSE;
                    end
                end
            end
            default: d.eng = E_IDLE;
        endcase

        // Triggers act on the registered queue state; a running queue ignores them.
        if (trig_q1) begin
            if (q.st1 == Q_OFF) begin
                d.st1  = Q_RUN;
                d.ptr1 = '0;
            end else if (q.st1 == Q_PAUSE) begin
                d.st1 = Q_RUN;
            end
        end
        if (trig_q2) begin
            if (q.st2 == Q_OFF) begin
                d.st2  = Q_RUN;
                d.ptr2 = {1'b0, q2_base};
            end else if (q.st2 == Q_PAUSE) begin
                d.st2 = Q_RUN;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            q.eng     <= E_IDLE;
            q.st1     <= Q_OFF;
            q.st2     <= Q_OFF;
        end else begin
            q <= d;
        end
    end

    assign conv_sample = (q.eng == E_HOLD);
    assign conv_start  = (q.eng == E_START);
    assign conv_chan   = q.chan;
    assign conv_ref    = q.ref_sel;
endmodule

// File: rtl/adc_cmd_sequencer.sv
module adc_cmd_sequencer #(
    parameter int AW     = 6,
    parameter int CMD_W  = 16,
    parameter int RES_W  = 10,
    parameter int OUT_W  = 16,
    parameter int SAMP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [AW-1:0]    cmd_waddr,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic [AW-1:0]    q2_base,
    input  logic             trig_q1,
    input  logic             trig_q2,
    output logic             conv_sample,
    output logic             conv_start,
    output logic [AW-1:0]    conv_chan,
    output logic             conv_ref,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    input  logic [AW-1:0]    rd_addr,
    input  logic [1:0]       rd_fmt,
    output logic [OUT_W-1:0] rd_data
);
    logic [AW-1:0]    cmd_raddr;
    logic [CMD_W-1:0] cmd_rdata;
    logic             res_we;
    logic [AW-1:0]    res_waddr;

    cmd_table #(.AW(AW), .DW(CMD_W)) u_cmd (
        .clk   (clk),
        .we    (cmd_we),
        .waddr (cmd_waddr),
        .wdata (cmd_wdata),
        .raddr (cmd_raddr),
        .rdata (cmd_rdata)
    );

    seq_ctrl #(.AW(AW), .DW(CMD_W), .SAMP_W(SAMP_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_q1     (trig_q1),
        .trig_q2     (trig_q2),
        .q2_base     (q2_base),
        .cmd_raddr   (cmd_raddr),
        .cmd_rdata   (cmd_rdata),
        .conv_sample (conv_sample),
        .conv_start  (conv_start),
        .conv_chan   (conv_chan),
        .conv_ref    (conv_ref),
        .conv_done   (conv_done),
        .res_we      (res_we),
        .res_waddr   (res_waddr)
    );

    result_table #(.AW(AW), .RW(RES_W), .OUT_W(OUT_W)) u_res (
        .clk   (clk),
        .we    (res_we),
        .waddr (res_waddr),
        .wdata (conv_data),
        .raddr (rd_addr),
        .fmt   (rd_fmt),
        .rdata (rd_data)
    );
endmodule

// File: rtl/adc_cmd_sequencer_chk.sv
module adc_cmd_sequencer_chk #(
    parameter int AW       = 6,
    parameter int MAX_HOLD = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          conv_sample,
    input logic          conv_start,
    input logic [AW-1:0] conv_chan,
    input logic          conv_ref
);
    localparam int CW = $clog2(MAX_HOLD + 1) + 1;

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)           run_q <= '0;
        else if (conv_sample) run_q <= run_q + CW'(1);
        else if (!conv_start) run_q <= '0;
    end

    // R2: start follows the sample phase directly
    a_r2_start_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(conv_sample));

    // R2: start lasts one cycle
    a_r2_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R2: phases never overlap
    a_r2_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_start && conv_sample));

    // R2: the sample run before a start is 2, 4, 8 or 16 cycles
    a_r2_hold_length: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ($countones(run_q) == 1 && run_q >= CW'(2) && run_q <= CW'(MAX_HOLD)));

    // R1: channel and reference stay put while sampling
    a_r1_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_sample && $past(conv_sample)) |-> ($stable(conv_chan) && $stable(conv_ref)));

    // R6: the end-of-queue code is never converted
    a_r6_eoq_not_converted: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (conv_chan != '1));
endmodule

bind adc_cmd_sequencer adc_cmd_sequencer_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_sample (conv_sample),
    .conv_start  (conv_start),
    .conv_chan   (conv_chan),
    .conv_ref    (conv_ref)
);

// File: tb/tb_adc_cmd_sequencer.sv
module tb_adc_cmd_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [5:0]  cmd_waddr = '0;
    logic [15:0] cmd_wdata = '0;
    logic [5:0]  q2_base = 6'd20;
    logic        trig_q1 = 1'b0;
    logic        trig_q2 = 1'b0;
    logic        conv_sample, conv_start, conv_ref;
    logic [5:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [9:0]  conv_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [1:0]  rd_fmt = '0;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    adc_cmd_sequencer dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_waddr(cmd_waddr),
        .cmd_wdata(cmd_wdata), .q2_base(q2_base), .trig_q1(trig_q1), .trig_q2(trig_q2),
        .conv_sample(conv_sample), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_ref(conv_ref), .conv_done(conv_done), .conv_data(conv_data),
        .rd_addr(rd_addr), .rd_fmt(rd_fmt), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    typedef struct packed {
        logic [15:0] word;
        logic [9:0]  data;
        logic [5:0]  chan;
        logic        rsel;
        logic [4:0]  hold;
    } vec_t;

    // Queue 1 entries 0..4: channel bits 5:0, sample code bits 7:6, reference bit 8, pause bit 9
    localparam vec_t VECS [5] = '{
        '{16'h0005, 10'h3FF, 6'd5,  1'b0, 5'd2},
        '{16'h014C, 10'h200, 6'd12, 1'b1, 5'd4},
        '{16'h00A1, 10'h000, 6'd33, 1'b0, 5'd8},
        '{16'h01FE, 10'h1FF, 6'd62, 1'b1, 5'd16},
        '{16'h0000, 10'h155, 6'd0,  1'b0, 5'd2}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_cmd(input logic [5:0] a, input logic [15:0] w);
        @(negedge clk);
        cmd_we = 1'b1; cmd_waddr = a; cmd_wdata = w;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic pulse(input bit q2);
        @(negedge clk);
        if (q2) trig_q2 = 1'b1; else trig_q1 = 1'b1;
        @(negedge clk);
        trig_q1 = 1'b0; trig_q2 = 1'b0;
    endtask

    // Converter model: counts sample cycles, captures fields at start, returns data.
    task automatic serve(input logic [9:0] data, input bit t1,
                         output logic [5:0] ch, output logic r, output int hold);
        hold = 0;
        while (!conv_start) begin
            if (conv_sample) hold++;
            @(negedge clk);
        end
        ch = conv_chan; r = conv_ref;
        @(negedge clk);
        conv_done = 1'b1; conv_data = data; trig_q1 = t1;
        @(negedge clk);
        conv_done = 1'b0; trig_q1 = 1'b0;
    endtask

    task automatic expect_idle(input int n, input string req);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (conv_start || conv_sample) seen = 1;
        end
        chk(!seen, req, int'(seen), 0);
    endtask

    task automatic serve_expect(input logic [9:0] data, input bit t1,
                                input logic [5:0] exp_ch, input string req);
        logic [5:0] ch; logic r; int h;
        serve(data, t1, ch, r, h);
        chk(ch == exp_ch, req, ch, exp_ch);
    endtask

    initial begin
        logic [5:0] ch;
        logic       r;
        int         h;
        logic [9:0] dv;

        // R14: reset state
        repeat (3) @(negedge clk);
        chk(conv_start == 1'b0 && conv_sample == 1'b0, "R14 outputs low in reset", conv_start, 0);
        rst_n = 1'b1;
        expect_idle(10, "R14 no activity without trigger");

        for (int i = 0; i < 5; i++) wr_cmd(6'(i), VECS[i].word);
        wr_cmd(6'd5, 16'h003F);
        wr_cmd(6'd20, 16'h0207);
        wr_cmd(6'd21, 16'h0009);
        wr_cmd(6'd22, 16'h003F);

        // R1 R2 R3 R8: queue 1 walk; R13: trigger at own completion is ignored
        pulse(1'b0);
        for (int i = 0; i < 5; i++) begin
            serve(VECS[i].data, (i == 2), ch, r, h);
            chk(ch == VECS[i].chan, "R3 R13 channel order", ch, VECS[i].chan);
            chk(r == VECS[i].rsel, "R1 reference select", r, VECS[i].rsel);
            chk(h == int'(VECS[i].hold), "R2 sample length", h, VECS[i].hold);
        end
        expect_idle(40, "R6 end code stops queue 1");

        // R8-R11: result readback in every alignment
        for (int i = 0; i < 5; i++) begin
            dv = VECS[i].data;
            @(negedge clk); rd_addr = 6'(i); rd_fmt = 2'd0; #1;
            chk(rd_data == {6'b0, dv}, "R8 R9 right aligned", rd_data, {6'b0, dv});
            rd_fmt = 2'd1; #1;
            chk(rd_data == {dv, 6'b0}, "R10 left aligned", rd_data, {dv, 6'b0});
            rd_fmt = 2'd2; #1;
            chk(rd_data == {~dv[9], dv[8:0], 6'b0}, "R11 signed", rd_data, {~dv[9], dv[8:0], 6'b0});
            rd_fmt = 2'd3; #1;
            chk(rd_data == {6'b0, dv}, "R9 code 3 right aligned", rd_data, {6'b0, dv});
        end

        // R5 R7: queue 2 from q2_base, pause at entry 20
        pulse(1'b1);
        serve_expect(10'h2AA, 1'b0, 6'd7, "R5 queue 2 first entry");
        expect_idle(40, "R7 paused after flagged entry");
        pulse(1'b1);
        serve_expect(10'h0F0, 1'b0, 6'd9, "R7 resumes at next entry");
        expect_idle(30, "R6 end code stops queue 2");
        @(negedge clk); rd_addr = 6'd21; rd_fmt = 2'd0; #1;
        chk(rd_data == 16'h00F0, "R8 queue 2 result index", rd_data, 16'h00F0);

        // R4: queue 1 ends at the boundary without converting it
        q2_base = 6'd3;
        pulse(1'b0);
        serve_expect(10'h001, 1'b0, 6'd5,  "R4 entry 0");
        serve_expect(10'h002, 1'b0, 6'd12, "R4 entry 1");
        serve_expect(10'h003, 1'b0, 6'd33, "R4 entry 2");
        expect_idle(40, "R4 stop at boundary");

        // R12: queue 1 trigger in the same cycle as a queue 2 completion
        q2_base = 6'd20;
        wr_cmd(6'd20, 16'h0007);
        pulse(1'b1);
        serve_expect(10'h111, 1'b1, 6'd7, "R12 queue 2 first");
        for (int i = 0; i < 5; i++)
            serve_expect(10'h100, 1'b0, VECS[i].chan, "R12 queue 1 preempts");
        serve_expect(10'h122, 1'b0, 6'd9, "R12 queue 2 resumes");
        expect_idle(30, "R12 both queues stopped");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule